// File: doc/BRIEF.md
# Low-Side Switch Channel Fault Supervisor

This block is the digital control for a single channel of a low-side power switch. An active-low command decides whether the switch should conduct. Three digitised comparator flags report the drain-source voltage: above the overload threshold, below the open-load threshold, and below the short-to-ground threshold. The block drives the gate enable for the power stage. It also keeps a 2-bit fault code that a diagnostic shift register reads.

The check that runs depends on the command. While the switch conducts, the block watches for overload. A persistent overload records the fault and latches the switch off, and the command must be released and then reasserted to clear that latch. While the switch is commanded off, the block watches for a shorted output and for an open load. Each check has its own persistence time, set in clock cycles. A short takes priority over an open load. A newer fault replaces the stored one.

The command and the flags pass through two-flop synchronisers. A clear pulse from the diagnostic interface resets the stored code. Reset and an undervoltage indication disable the switch and clear all state.

Top module: `lsw_chan_supervisor`

## Requirements
- R1: While `rst_ni` is low, `gate_en_o` is 0 and `fault_code_o` is 11. While `uv_i` is high, `gate_en_o` is 0 in the same cycle. The code reads 11 one edge after `uv_i` is sampled high, and any overload latch is cleared.
- R2: `cmd_ni` is active low. A change on it reaches `gate_en_o` after exactly two rising edges (the synchroniser), provided no latch or undervoltage holds the gate off.
- R3: While the gate is on, an overload flag held for OVL_DLY consecutive synchronised cycles sets the code to 10 and drops `gate_en_o`. Both changes appear OVL_DLY+2 edges after the flag first reaches the input. A run of OVL_DLY-1 cycles has no effect.
- R4: After an overload shutdown, `gate_en_o` stays 0 while the command stays active. It returns only after the command is seen inactive (high) and then active (low) again.
- R5: While commanded off, an open-load flag held for OL_DLY synchronised cycles, with the short flag low, sets the code to 01. A run of OL_DLY-1 cycles has no effect.
- R6: While commanded off, a short flag held for SH_DLY synchronised cycles sets the code to 00. While the short flag is high, the open-load check is held in restart, so a true short never ends up coded as open load.
- R7: The overload flag is ignored while the gate is off. The open-load and short flags are ignored while the command is active.
- R8: Every new fault overwrites the stored code, whatever code it held before.
- R9: A one-cycle `clr_fault_i` pulse sets the code to 11 at the next edge and leaves the overload latch unchanged. If a fault trips on the same edge, the fault code wins.
- R10: Each persistence count restarts from zero whenever its flag drops or its mode condition ends. Two runs of length DLY-1 separated by one low cycle do not trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_ni | input | 1 | Switch command, low = conduct |
| uv_i | input | 1 | Supply undervoltage indication, synchronous |
| ovl_flag_i | input | 1 | Drain-source voltage above the overload threshold |
| ol_flag_i | input | 1 | Drain-source voltage below the open-load threshold |
| sh_flag_i | input | 1 | Drain-source voltage below the short-to-ground threshold |
| clr_fault_i | input | 1 | One-cycle request to reset the stored code to 11 |
| gate_en_o | output | 1 | Gate enable for the power stage |
| fault_code_o | output | 2 | 11 none, 10 overload, 01 open load, 00 short to ground |

## Verification
The command reaches the gate two edges after it changes. A flag held from its first input cycle trips at edge DLY+2, and the code and gate update on that same edge. Clear and undervoltage act at the first edge. The bench drives every input at a falling edge and samples at falling edges. For the overload it checks the cycle just before the trip edge and the cycle just after it. The boundary runs of DLY-1 and DLY input cycles are timed the same way. The same-edge race between clear and a trip is set up by placing the clear pulse on the predicted trip edge.

// File: rtl/lsw_sup_pkg.sv
package lsw_sup_pkg;
  typedef enum logic [1:0] {
    FLT_SHORT = 2'b00,
    FLT_OPEN  = 2'b01,
    FLT_OVL   = 2'b10,
    FLT_NONE  = 2'b11
  } fault_e;

  localparam int unsigned N_CHECKS = 3;
  localparam int unsigned CHK_OVL  = 0;
  localparam int unsigned CHK_SH   = 1;
  localparam int unsigned CHK_OL   = 2;
endpackage

// File: rtl/lsw_sync2.sv
module lsw_sync2 #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/lsw_persist_timer.sv
module lsw_persist_timer #(
  parameter int unsigned DLY = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] CNT_HIT = CW'(DLY - 1);
  localparam logic [CW-1:0] CNT_SAT = CW'(DLY);

  logic [CW-1:0] cnt_q;

  // saturate one past the hit value so a long run trips once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!active_i)       cnt_q <= '0;
    else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = active_i && (cnt_q == CNT_HIT);

  a_r10_single_trip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o |=> !expired_o);
endmodule

// File: rtl/lsw_fault_reg.sv
module lsw_fault_reg
  import lsw_sup_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       uv_i,
  input  logic       ovl_trip_i,
  input  logic       sh_trip_i,
  input  logic       ol_trip_i,
  input  logic       clr_i,
  output logic [1:0] code_o
);
  fault_e code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         code_q <= FLT_NONE;
    else if (uv_i)       code_q <= FLT_NONE;
    else if (sh_trip_i)  code_q <= FLT_SHORT;
    else if (ol_trip_i)  code_q <= FLT_OPEN;
    else if (ovl_trip_i) code_q <= FLT_OVL;
    else if (clr_i)      code_q <= FLT_NONE;
  end

  assign code_o = code_q;

  a_r1_uv_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> code_o == FLT_NONE);
  a_r6_short_recorded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_trip_i && !uv_i) |=> code_o == FLT_SHORT);
  a_r9_clear_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !uv_i && !sh_trip_i && !ol_trip_i && !ovl_trip_i) |=> code_o == FLT_NONE);
  a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !uv_i && !sh_trip_i && !ol_trip_i && !ovl_trip_i) |=> $stable(code_o));
endmodule

// File: rtl/lsw_chan_supervisor.sv
module lsw_chan_supervisor
  import lsw_sup_pkg::*;
#(
  parameter int unsigned OVL_DLY = 10000,
  parameter int unsigned OL_DLY  = 6250,
  parameter int unsigned SH_DLY  = 3750
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_ni,
  input  logic       uv_i,
  input  logic       ovl_flag_i,
  input  logic       ol_flag_i,
  input  logic       sh_flag_i,
  input  logic       clr_fault_i,
  output logic       gate_en_o,
  output logic [1:0] fault_code_o
);
  localparam int unsigned SW = 4;

  logic [SW-1:0] raw, syn;
  logic cmd_on, ovl_s, ol_s, sh_s;
  logic latch_q;
  logic [N_CHECKS-1:0] act, trip;

  assign raw = {cmd_ni, ovl_flag_i, ol_flag_i, sh_flag_i};

  lsw_sync2 #(.W(SW), .RST_VAL(4'b1000)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign cmd_on = ~syn[3];
  assign ovl_s  = syn[2];
  assign ol_s   = syn[1];
  assign sh_s   = syn[0];

  assign gate_en_o = cmd_on & ~latch_q & ~uv_i;

  // mode qualification; short holds the open-load count in restart
  assign act[CHK_OVL] = gate_en_o & ovl_s;
  assign act[CHK_SH]  = ~cmd_on & ~uv_i & sh_s;
  assign act[CHK_OL]  = ~cmd_on & ~uv_i & ol_s & ~sh_s;

  for (genvar g = 0; g < N_CHECKS; g++) begin : g_chk
    localparam int unsigned D = (g == CHK_OVL) ? OVL_DLY :
                                (g == CHK_SH)  ? SH_DLY  : OL_DLY;
    lsw_persist_timer #(.DLY(D)) u_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (act[g]),
      .expired_o(trip[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             latch_q <= 1'b0;
    else if (uv_i)           latch_q <= 1'b0;
    else if (trip[CHK_OVL])  latch_q <= 1'b1;
    else if (!cmd_on)        latch_q <= 1'b0;
  end

  lsw_fault_reg u_freg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .uv_i      (uv_i),
    .ovl_trip_i(trip[CHK_OVL]),
    .sh_trip_i (trip[CHK_SH]),
    .ol_trip_i (trip[CHK_OL]),
    .clr_i     (clr_fault_i),
    .code_o    (fault_code_o)
  );

  a_r3_trip_kills_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip[CHK_OVL] && !uv_i) |=> !gate_en_o);
  a_r4_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && cmd_on && !uv_i) |=> latch_q);
  a_r7_modes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trip[CHK_OVL] && (trip[CHK_SH] || trip[CHK_OL])));
  a_r6_short_blocks_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_s |-> !trip[CHK_OL]);
endmodule

// File: tb/lsw_chan_supervisor_bench.sv
`timescale 1ns/1ps
module lsw_chan_supervisor_bench;
  localparam int unsigned OVL = 12;
  localparam int unsigned OL  = 10;
  localparam int unsigned SH  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_n = 1'b1, uv = 1'b0, ovl = 1'b0, ol = 1'b0, sh = 1'b0, clr = 1'b0;
  logic gate;
  logic [1:0] code;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lsw_chan_supervisor #(.OVL_DLY(OVL), .OL_DLY(OL), .SH_DLY(SH)) u_lsw_chan_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .cmd_ni(cmd_n), .uv_i(uv),
    .ovl_flag_i(ovl), .ol_flag_i(ol), .sh_flag_i(sh), .clr_fault_i(clr),
    .gate_en_o(gate), .fault_code_o(code)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // which: 0 ovl, 1 ol, 2 sh, 3 ol+sh
  task automatic pulse(input int which, input int n);
    @(negedge clk);
    ovl = (which == 0); ol = (which == 1 || which == 3); sh = (which == 2 || which == 3);
    wait_n(n);
    ovl = 0; ol = 0; sh = 0;
    wait_n(4);
  endtask

  task automatic set_cmd(input logic v);
    @(negedge clk); cmd_n = v; wait_n(3);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
  endtask

  task automatic t_reset();
    wait_n(2);
    chk("R1 gate in reset", {1'b0, gate}, 2'b00);
    chk("R1 code in reset", code, 2'b11);
    @(negedge clk); rst_n = 1; wait_n(3);
    chk("R1 code after reset", code, 2'b11);
  endtask

  task automatic t_cmd_latency();
    @(negedge clk); cmd_n = 0;
    @(negedge clk); chk("R2 gate one edge", {1'b0, gate}, 2'b00);
    @(negedge clk); chk("R2 gate two edges", {1'b0, gate}, 2'b01);
    @(negedge clk); cmd_n = 1;
    @(negedge clk); chk("R2 release one edge", {1'b0, gate}, 2'b01);
    @(negedge clk); chk("R2 release two edges", {1'b0, gate}, 2'b00);
  endtask

  task automatic t_overload();
    set_cmd(0);
    pulse(0, OVL - 1);
    chk("R3 short run code", code, 2'b11);
    chk("R3 short run gate", {1'b0, gate}, 2'b01);
    @(negedge clk); ovl = 1;
    wait_n(OVL + 1);
    chk("R3 before trip code", code, 2'b11);
    chk("R3 before trip gate", {1'b0, gate}, 2'b01);
    @(negedge clk);
    chk("R3 trip code", code, 2'b10);
    chk("R3 trip gate", {1'b0, gate}, 2'b00);
    ovl = 0; wait_n(4);
  endtask

  task automatic t_latch();
    do_clear();
    chk("R9 clear code", code, 2'b11);
    wait_n(3);
    chk("R9 clear keeps latch", {1'b0, gate}, 2'b00);
    chk("R4 still latched", {1'b0, gate}, 2'b00);
    set_cmd(1);
    set_cmd(0);
    chk("R4 rearmed gate", {1'b0, gate}, 2'b01);
    set_cmd(1);
  endtask

  task automatic t_ignore();
    pulse(0, 3 * OVL);
    chk("R7 ovl ignored while off", code, 2'b11);
    set_cmd(0);
    pulse(3, 3 * OL);
    chk("R7 ol/sh ignored while on", code, 2'b11);
    chk("R7 gate unaffected", {1'b0, gate}, 2'b01);
    set_cmd(1);
  endtask

  task automatic t_open_short();
    pulse(1, OL - 1);
    chk("R5 short run", code, 2'b11);
    pulse(1, OL);
    chk("R5 open load", code, 2'b01);
    do_clear();
    pulse(2, SH - 1);
    chk("R6 short run", code, 2'b11);
    pulse(3, 3 * OL);
    chk("R6 short wins over open", code, 2'b00);
  endtask

  task automatic t_overwrite();
    pulse(1, OL);
    chk("R8 open over short", code, 2'b01);
    set_cmd(0);
    pulse(0, OVL);
    chk("R8 overload over open", code, 2'b10);
    set_cmd(1);
    pulse(2, SH);
    chk("R8 short over overload", code, 2'b00);
    do_clear();
  endtask

  task automatic t_restart();
    @(negedge clk); ol = 1; wait_n(OL - 1);
    ol = 0; @(negedge clk);
    ol = 1; wait_n(OL - 1);
    ol = 0; wait_n(4);
    chk("R10 restart on drop", code, 2'b11);
  endtask

  task automatic t_clear_race();
    @(negedge clk); sh = 1;
    wait_n(SH + 1);
    clr = 1; @(negedge clk); clr = 0;
    chk("R9 trip beats clear", code, 2'b00);
    sh = 0; wait_n(3);
    do_clear();
    chk("R9 later clear", code, 2'b11);
  endtask

  task automatic t_uv();
    set_cmd(0);
    pulse(0, OVL);
    chk("R1 pre-uv overload", code, 2'b10);
    @(negedge clk); uv = 1; #1;
    chk("R1 uv gate off", {1'b0, gate}, 2'b00);
    @(negedge clk);
    chk("R1 uv clears code", code, 2'b11);
    uv = 0; @(negedge clk);
    chk("R1 uv clears latch", {1'b0, gate}, 2'b01);
    set_cmd(1);
  endtask

  initial begin
    t_reset();
    t_cmd_latency();
    t_overload();
    t_latch();
    t_ignore();
    t_open_short();
    t_overwrite();
    t_restart();
    t_clear_race();
    t_uv();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule